// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the write path of a byte-wide nonvolatile memory and decides, for every byte-write strobe, whether that write may reach the array. It holds one protection flag. While the flag is clear, ordinary writes pass. While it is set, writes are refused unless a three-write arming sequence has just opened a page-load window. A six-write release sequence clears the flag and returns the memory to unrestricted writing.

The arming sequence always sets the flag, even if it was clear before. It then permits a burst of loads into one page. The window shuts when the page is full, or after a fixed number of clock edges pass with no write strobe, and the memory stays protected afterwards. Writes that form part of a recognised sequence are consumed by the detector and are never permitted to the array. A separate load port restores the flag from a persistent copy at start-up.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset, prot_on and win_open are 0, and an ordinary write is permitted.
- R2: Address matching for sequence steps uses only address bits [14:0]; the values of bits 15 and 16 do not matter.
- R3: The arming sequence is (data 0xAA, address 0x5555), then (0x55, 0x2AAA), then (0xA0, 0x5555), on three strobes with no other strobe between them. At the clock edge of the third write, prot_on becomes 1 and win_open becomes 1. None of these three writes is permitted.
- R4: Completing the arming sequence sets prot_on even if it was 0 before.
- R5: While prot_on is 1 and win_open is 0, no write is permitted.
- R6: While the window is open, ordinary writes are permitted. The window closes at the edge of the 2**PAGE_W-th permitted load, and later loads are refused.
- R7: The window closes after LOAD_GAP consecutive clock edges with no strobe. A load that arrives after LOAD_GAP-1 idle edges is still permitted.
- R8: The first permitted load in a window fixes the page, which is address bits [ADDR_W-1:PAGE_W]. Loads in the same window to any other page are refused and do not count toward the page size.
- R9: The release sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. At the edge of its last write, prot_on and win_open become 0. None of the six writes is permitted.
- R10: A strobe that does not match the expected next step returns the matcher to its first step. That strobe is judged as an ordinary write under the current flag and window. It is not itself re-tried as a first step.
- R11: A cycle with nv_load high sets prot_on to nv_prot, closes the window and returns the matcher to its first step, all at the next edge.
- R12: wr_permit is high only in a cycle where wr_stb is high. It is combinational from that cycle's inputs and state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_load | input | 1 | Load the protection flag from the persistent copy |
| nv_prot | input | 1 | Persistent flag value taken when nv_load is high |
| wr_stb | input | 1 | One-cycle pulse per captured byte write |
| wr_addr | input | ADDR_W (17) | Captured write address |
| wr_data | input | DATA_W (8) | Captured write data |
| wr_permit | output | 1 | This strobe may be written to the array |
| prot_on | output | 1 | Protection flag |
| win_open | output | 1 | Page-load window after arming is open |

## Verification
The bench builds the block with PAGE_W = 2 and LOAD_GAP = 12, and keeps the full 17-bit address with a 15-bit match field. A four-byte page lets the bench reach the page-full closure and the refused fifth load within a few cycles. A twelve-edge gap lets it hit the idle-timeout boundary exactly one edge on each side. The untouched upper address bits let sequence steps carry bits 15 and 16 set, and let a load to a different page be refused inside an open window. A long stretch of random strobes, drawn mostly from the sequence codes, then drives partial and broken sequences against the behavioural model.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   // Data codes of the command sequences
   localparam logic [7:0] K_LEAD  = 8'hAA;
   localparam logic [7:0] K_FOLLOW = 8'h55;
   localparam logic [7:0] K_ARM   = 8'hA0;
   localparam logic [7:0] K_ERASE = 8'h80;
   localparam logic [7:0] K_CLEAR = 8'h20;

   // Command addresses (low address field only)
   localparam logic [15:0] K_ADDR_X = 16'h5555;
   localparam logic [15:0] K_ADDR_Y = 16'h2AAA;

   typedef enum logic [2:0] {
      ST_START = 3'd0,
      ST_GOT1  = 3'd1,
      ST_GOT2  = 3'd2,
      ST_GOT3  = 3'd3,
      ST_GOT4  = 3'd4,
      ST_GOT5  = 3'd5
   } step_t;

   typedef struct packed {
      logic take;     // strobe consumed as a sequence step
      logic arm_hit;  // arming sequence completed
      logic rel_hit;  // release sequence completed
   } match_res_t;

endpackage

// File: rtl/wpg_match.sv
module wpg_match
   import wpg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stb,
   input  logic [CMP_W-1:0]  addr_lo,
   input  logic [DATA_W-1:0] data,
   output match_res_t        res
);

   step_t step_q, step_d;
   logic  at_x, at_y;
   logic  is_lead, is_follow, is_arm, is_erase, is_clear;

   assign at_x      = (addr_lo == CMP_W'(K_ADDR_X));
   assign at_y      = (addr_lo == CMP_W'(K_ADDR_Y));
   assign is_lead   = (data == DATA_W'(K_LEAD));
   assign is_follow = (data == DATA_W'(K_FOLLOW));
   assign is_arm    = (data == DATA_W'(K_ARM));
   assign is_erase  = (data == DATA_W'(K_ERASE));
   assign is_clear  = (data == DATA_W'(K_CLEAR));

   always_comb begin
      res = '0;
      if (stb) begin
         unique case (step_q)
            ST_START: res.take = at_x & is_lead;
            ST_GOT1:  res.take = at_y & is_follow;
            ST_GOT2: begin
               res.take    = at_x & (is_arm | is_erase);
               res.arm_hit = at_x & is_arm;
            end
            ST_GOT3:  res.take = at_x & is_lead;
            ST_GOT4:  res.take = at_y & is_follow;
            ST_GOT5: begin
               res.take    = at_x & is_clear;
               res.rel_hit = at_x & is_clear;
            end
            default:  res = '0;
         endcase
      end
   end

   always_comb begin
      step_d = step_q;
      if (clr) begin
         step_d = ST_START;
      end else if (stb) begin
         if (res.take && !res.arm_hit && !res.rel_hit) begin
            step_d = step_t'(step_q + 3'd1);
         end else begin
            step_d = ST_START;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_START;
      end else begin
         step_q <= step_d;
      end
   end

endmodule

// File: rtl/wpg_window.sv
module wpg_window #(
   parameter int ADDR_W    = 17,
   parameter int PAGE_W    = 8,
   parameter int LOAD_GAP  = 10000,
   parameter bit PAGE_LOCK = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     open_req,
   input  logic                     close_req,
   input  logic                     stb,
   input  logic                     cand,
   input  logic [ADDR_W-PAGE_W-1:0] page_in,
   output logic                     win_open,
   output logic                     load_ok
);

   localparam int PG_BYTES = 1 << PAGE_W;
   localparam int CNT_W    = PAGE_W + 1;
   localparam int TMR_W    = $clog2(LOAD_GAP + 1);
   localparam int PGN_W    = ADDR_W - PAGE_W;

   logic             open_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TMR_W-1:0] tmr_q;
   logic             same_pg;
   logic             page_full;
   logic             gap_over;

   assign load_ok   = cand & open_q & same_pg;
   assign page_full = load_ok && (cnt_q == CNT_W'(PG_BYTES - 1));
   assign gap_over  = !stb && (tmr_q == TMR_W'(LOAD_GAP - 1));
   assign win_open  = open_q;

   generate
      if (PAGE_LOCK) begin : g_lock
         logic [PGN_W-1:0] pg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pg_q <= '0;
            end else if (load_ok && cnt_q == '0) begin
               pg_q <= page_in;
            end
         end
         assign same_pg = (cnt_q == '0) || (page_in == pg_q);
      end else begin : g_free
         assign same_pg = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         tmr_q  <= '0;
      end else if (open_req) begin
         open_q <= 1'b1;
         cnt_q  <= '0;
         tmr_q  <= '0;
      end else if (close_req) begin
         open_q <= 1'b0;
      end else if (open_q) begin
         if (load_ok) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (stb) begin
            tmr_q <= '0;
         end else begin
            tmr_q <= tmr_q + 1'b1;
         end
         if (page_full || gap_over) begin
            open_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wpg_flag.sv
module wpg_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic ld_val,
   input  logic set_req,
   input  logic clr_req,
   output logic prot
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot <= 1'b0;
      end else if (ld) begin
         prot <= ld_val;
      end else if (set_req) begin
         prot <= 1'b1;
      end else if (clr_req) begin
         prot <= 1'b0;
      end
   end

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
   import wpg_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CMP_W     = 15,
   parameter int PAGE_W    = 8,
   parameter int LOAD_GAP  = 10000,
   parameter bit PAGE_LOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_load,
   input  logic              nv_prot,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_permit,
   output logic              prot_on,
   output logic              win_open
);

   generate
      if (CMP_W < 14 || CMP_W > ADDR_W) begin : g_bad_cmp
         $error("wp_seq_guard: CMP_W must lie in 14..ADDR_W");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("wp_seq_guard: PAGE_W must lie in 1..ADDR_W-1");
      end
      if (LOAD_GAP < 1) begin : g_bad_gap
         $error("wp_seq_guard: LOAD_GAP must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("wp_seq_guard: DATA_W must be at least 8");
      end
   endgenerate

   match_res_t mres;
   logic       cand;
   logic       load_ok;

   wpg_match #(
      .DATA_W (DATA_W),
      .CMP_W  (CMP_W)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (nv_load),
      .stb     (wr_stb),
      .addr_lo (wr_addr[CMP_W-1:0]),
      .data    (wr_data),
      .res     (mres)
   );

   assign cand = wr_stb & ~mres.take;

   wpg_window #(
      .ADDR_W    (ADDR_W),
      .PAGE_W    (PAGE_W),
      .LOAD_GAP  (LOAD_GAP),
      .PAGE_LOCK (PAGE_LOCK)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (mres.arm_hit & ~nv_load),
      .close_req (mres.rel_hit | nv_load),
      .stb       (wr_stb),
      .cand      (cand),
      .page_in   (wr_addr[ADDR_W-1:PAGE_W]),
      .win_open  (win_open),
      .load_ok   (load_ok)
   );

   wpg_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (nv_load),
      .ld_val  (nv_prot),
      .set_req (mres.arm_hit),
      .clr_req (mres.rel_hit),
      .prot    (prot_on)
   );

   assign wr_permit = cand & (~prot_on | load_ok);

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic nv_load,
   input logic nv_prot,
   input logic wr_stb,
   input logic wr_permit,
   input logic prot_on,
   input logic win_open
);

   AST_PERMIT_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> wr_stb); // R12

   AST_NVLOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_load |=> (prot_on == $past(nv_prot))); // R11

   AST_NVLOAD_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      nv_load |=> !win_open); // R11

   AST_LOCKED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && !win_open) |-> !wr_permit); // R5

   AST_WIN_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> prot_on); // R3

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!nv_load && !wr_stb) |=> $stable(prot_on)); // R9

   AST_WIN_OPENS_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(wr_stb)); // R3

endmodule

bind wp_seq_guard wp_seq_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nv_load   (nv_load),
   .nv_prot   (nv_prot),
   .wr_stb    (wr_stb),
   .wr_permit (wr_permit),
   .prot_on   (prot_on),
   .win_open  (win_open)
);

// File: tb/wp_seq_guard_bench.sv
module wp_seq_guard_bench;

   localparam int AW  = 17;
   localparam int DW  = 8;
   localparam int PW  = 2;
   localparam int GAP = 12;
   localparam int PB  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nv_load = 1'b0;
   logic          nv_prot = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_permit, prot_on, win_open;

   always #5 clk = ~clk;

   wp_seq_guard #(
      .ADDR_W(AW), .DATA_W(DW), .CMP_W(15), .PAGE_W(PW),
      .LOAD_GAP(GAP), .PAGE_LOCK(1'b1)
   ) u_wp_seq_guard (
      .clk(clk), .rst_n(rst_n), .nv_load(nv_load), .nv_prot(nv_prot),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_permit(wr_permit), .prot_on(prot_on), .win_open(win_open)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string tag = "R1";
   string next_tag = "R1";

   // behavioural reference state
   bit        m_prot, m_win;
   int        m_cnt, m_idle;
   int        m_page;
   bit [7:0]  m_seen[$];
   bit        e_take, e_arm, e_rel, e_ord, e_perm;
   int        pos;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit step_ok(int p, logic [AW-1:0] a, logic [7:0] d);
      logic [14:0] la;
      la = a[14:0];
      case (p)
         0: return la == 15'h5555 && d == 8'hAA;
         1: return la == 15'h2AAA && d == 8'h55;
         2: return la == 15'h5555 && (d == 8'hA0 || d == 8'h80);
         3: return la == 15'h5555 && d == 8'hAA;
         4: return la == 15'h2AAA && d == 8'h55;
         5: return la == 15'h5555 && d == 8'h20;
         default: return 1'b0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_prot = 0; m_win = 0; m_cnt = 0; m_idle = 0; m_page = 0;
         m_seen.delete();
         chk("R1", "reset prot_on", prot_on, 0);
         chk("R1", "reset win_open", win_open, 0);
      end else begin
         e_take = 0; e_arm = 0; e_rel = 0;
         if (wr_stb) begin
            pos = m_seen.size();
            if (step_ok(pos, wr_addr, wr_data)) begin
               e_take = 1;
               if (pos == 2 && wr_data == 8'hA0) e_arm = 1;
               if (pos == 5) e_rel = 1;
            end
         end
         e_ord  = wr_stb && !e_take;
         e_perm = e_ord && (!m_prot ||
                  (m_win && (m_cnt == 0 || int'(wr_addr[AW-1:PW]) == m_page)));
         chk(tag, "wr_permit", wr_permit, e_perm);
         chk(tag, "prot_on", prot_on, m_prot);
         chk(tag, "win_open", win_open, m_win);
         // advance the model as the coming edge will
         if (nv_load) begin
            m_prot = nv_prot; m_win = 0; m_seen.delete();
         end else begin
            if (wr_stb) begin
               if (e_take && !e_arm && !e_rel) m_seen.push_back(wr_data);
               else m_seen.delete();
            end
            if (e_arm) begin
               m_prot = 1; m_win = 1; m_cnt = 0; m_idle = 0;
            end else if (e_rel) begin
               m_prot = 0; m_win = 0;
            end else if (m_win) begin
               if (e_perm) begin
                  if (m_cnt == 0) m_page = int'(wr_addr[AW-1:PW]);
                  m_cnt++;
                  if (m_cnt == PB) m_win = 0;
               end
               if (wr_stb) m_idle = 0;
               else begin
                  m_idle++;
                  if (m_idle == GAP) m_win = 0;
               end
            end
         end
      end
   end

   task automatic drive(bit s, logic [AW-1:0] a, logic [7:0] d);
      @(posedge clk);
      #1;
      tag = next_tag;
      wr_stb = s; wr_addr = a; wr_data = d; nv_load = 1'b0;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      drive(1'b1, a, d);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(1'b0, '0, '0);
   endtask

   task automatic nvload(bit v);
      @(posedge clk);
      #1;
      tag = next_tag;
      wr_stb = 1'b0; nv_load = 1'b1; nv_prot = v;
   endtask

   task automatic arm(logic [AW-1:0] hi);
      wr(hi | 17'h05555, 8'hAA);
      wr(hi | 17'h02AAA, 8'h55);
      wr(hi | 17'h05555, 8'hA0);
   endtask

   task automatic release_seq(logic [AW-1:0] hi);
      wr(17'h05555, 8'hAA);
      wr(hi | 17'h02AAA, 8'h55);
      wr(17'h05555, 8'h80);
      wr(hi | 17'h05555, 8'hAA);
      wr(17'h02AAA, 8'h55);
      wr(hi | 17'h05555, 8'h20);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      next_tag = "R1"; wr(17'h00100, 8'h3C); idle(1);
      // R4: arm from the unprotected state, with high address bits set (R2)
      next_tag = "R4"; arm(17'h18000);
      // R6: fill the four-byte page, fifth load refused
      next_tag = "R6";
      wr(17'h00040, 8'h01); wr(17'h00041, 8'h02); wr(17'h00042, 8'h03);
      wr(17'h00043, 8'h04); wr(17'h00040, 8'h05); idle(2);
      // R5: protected, no window
      next_tag = "R5"; wr(17'h00300, 8'h11); wr(17'h1FFFF, 8'h22); idle(1);
      // R3 and R7: idle gap boundary
      next_tag = "R3"; arm(17'h00000);
      next_tag = "R7"; wr(17'h00080, 8'h09); idle(11); wr(17'h00081, 8'h0A);
      idle(12); wr(17'h00082, 8'h0B); idle(1);
      // R8: page lock inside a window
      next_tag = "R8"; arm(17'h08000);
      wr(17'h0000C, 8'h21); wr(17'h00010, 8'h22); wr(17'h0000D, 8'h23);
      wr(17'h00500, 8'h24); wr(17'h0000E, 8'h25); wr(17'h0000F, 8'h26);
      wr(17'h0000C, 8'h27); idle(2);
      // R10: broken sequence while protected
      next_tag = "R10";
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h03333, 8'h12);
      wr(17'h05555, 8'hA0); wr(17'h00200, 8'h13); idle(1);
      // R9: release, then ordinary writes pass
      next_tag = "R9"; release_seq(17'h10000);
      wr(17'h00220, 8'h44); idle(1);
      // R9: release while a window is open
      arm(17'h00000); wr(17'h00600, 8'h55); release_seq(17'h00000);
      wr(17'h00700, 8'h66); idle(1);
      // R10: broken sequence while unprotected; breaking write passes
      next_tag = "R10";
      wr(17'h05555, 8'hAA); wr(17'h00200, 8'h77); wr(17'h02AAA, 8'h55);
      wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); idle(1);
      // R11: persistent load
      next_tag = "R11";
      nvload(1'b1); wr(17'h00010, 8'h88); nvload(1'b0); wr(17'h00011, 8'h99);
      arm(17'h00000); nvload(1'b0); wr(17'h00012, 8'h9A);
      nvload(1'b1); idle(1);
      // R12 and R10: random traffic biased towards command codes
      next_tag = "R12";
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a;
         logic [7:0]    d;
         int            r;
         r = $urandom_range(0, 99);
         case ($urandom_range(0, 3))
            0: a = 17'h05555;
            1: a = 17'h02AAA;
            default: a = 17'($urandom_range(0, 15));
         endcase
         a[16:15] = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 6))
            0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0;
            3: d = 8'h80; 4: d = 8'h20;
            default: d = 8'($urandom_range(0, 255));
         endcase
         if (r < 2) nvload(1'($urandom_range(0, 1)));
         else if (r < 70) wr(a, d);
         else idle(1);
      end
      idle(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule